// File: doc/BRIEF.md
# Operand Effective Address Generator

This unit turns an operand specifier into the address (or value) that the operand stage needs. Each request carries a 4-bit mode code, the contents of up to two general registers, the program counter, a displacement and an operand size code. The unit registers its result and returns it one cycle later with a one-cycle done pulse. The modes cover an immediate operand, a register operand, absolute addressing and register-indirect addressing. They also cover displacement plus register, two-register sums with or without a displacement, and program-counter-relative targets. Autoincrement and autodecrement step a register by the operand size.

Modes that change a register also return a writeback enable, the register index and the new register value, for the register file to apply. In memory-indirect mode the displacement is taken as the location of a pointer word. The unit asks an external memory port for that word and waits for the reply. It then hands back the fetched word as the final address.

A short-displacement flag selects whether the low byte of the displacement field is sign-extended to the full word before use. This lets one field carry both short signed offsets and full-width absolute locations.

Top module: `ea_gen`

## Requirements
- R1: After reset, `done_o`, `fetch_req_o`, `wb_en_o`, `busy_o`, `imm_o`, `reg_op_o` and `illegal_o` are all low.
- R2: For every mode except memory-indirect (code 4), a start accepted while idle gives `done_o` high for exactly the next cycle, with every result output valid in that cycle.
- R3: The working displacement X equals `disp_i` when `disp_short_i` is 0. When `disp_short_i` is 1, X is the low SHORT_W bits of `disp_i` sign-extended to AW bits.
- R4: Immediate mode (code 0) sets `imm_o` and returns X on `ea_o`; no fetch and no writeback take place.
- R5: Register mode (code 1) sets `reg_op_o` and returns Ri on `ea_o`. Absolute mode (code 2) returns X. Register-indirect mode (code 3) returns Ri.
- R6: Indexed mode (code 5) returns X+Ri. Base-plus-index (code 6) returns Ri+Rj. Base-plus-index-plus-offset (code 7) returns X+Ri+Rj. PC-relative (code 8) returns PC+X. All sums wrap modulo 2^AW.
- R7: Memory-indirect mode (code 4) raises `fetch_req_o` with `fetch_addr_o` = X from the cycle after the start. It holds both until a cycle in which `fetch_vld_i` is high. The next cycle has `done_o` high, `ea_o` equal to the `fetch_data_i` sampled in that cycle, and all flags low.
- R8: Autoincrement (code 9) returns Ri on `ea_o` and writes back Ri + 2^size. Autodecrement (code 10) returns Ri − 2^size on both `ea_o` and the writeback value. The size codes 0, 1, 2 and 3 mean steps of 1, 2, 4 and 8.
- R9: `wb_en_o` is high only in the done cycle of an autoincrement or autodecrement, with `wb_idx_o` equal to the `ra_idx_i` given at the start.
- R10: Mode codes 11 to 15 complete like R2 with `illegal_o` high, `ea_o` zero and no writeback.
- R11: A start raised while a memory-indirect fetch is pending is ignored: it produces no done pulse and no writeback, and the pending fetch completes as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe |
| mode_i | input | 4 | Addressing mode code |
| size_i | input | 2 | Operand size code (step = 2^size) |
| ra_idx_i | input | RW | Index of the first register (Ri) |
| ra_val_i | input | AW | Contents of Ri |
| rb_val_i | input | AW | Contents of Rj |
| pc_i | input | AW | Program counter |
| disp_i | input | AW | Displacement field |
| disp_short_i | input | 1 | Sign-extend the low SHORT_W bits of the displacement |
| fetch_vld_i | input | 1 | Pointer word reply valid |
| fetch_data_i | input | AW | Pointer word |
| fetch_req_o | output | 1 | Pointer word request |
| fetch_addr_o | output | AW | Pointer word location |
| busy_o | output | 1 | Memory-indirect fetch pending |
| done_o | output | 1 | Result valid pulse |
| ea_o | output | AW | Effective address or immediate value |
| imm_o | output | 1 | Operand is the immediate value |
| reg_op_o | output | 1 | Operand is the register itself |
| illegal_o | output | 1 | Unused mode code |
| wb_en_o | output | 1 | Register writeback enable |
| wb_idx_o | output | RW | Register writeback index |
| wb_val_o | output | AW | Register writeback value |

## Verification
The bench sweeps all sixteen mode codes against each operand size and both displacement forms. The register values used are zero, all-ones, the sign boundary and an ordinary pattern. These separate wrap-around in the sums from correct carries, and sign extension from zero extension. Displacements of 0x007F and 0x0080 sit on either side of the short sign boundary, while 0xFF80 and 0x1234 show whether high displacement bits are dropped or kept. The memory-indirect requests are answered after zero, one and two wait cycles to tell a held request from a pulsed one. A stray start during a pending fetch shows whether that start is ignored.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;

  localparam logic [3:0] AM_IMM   = 4'd0;
  localparam logic [3:0] AM_REG   = 4'd1;
  localparam logic [3:0] AM_ABS   = 4'd2;
  localparam logic [3:0] AM_RIND  = 4'd3;
  localparam logic [3:0] AM_MIND  = 4'd4;
  localparam logic [3:0] AM_IDX   = 4'd5;
  localparam logic [3:0] AM_BIDX  = 4'd6;
  localparam logic [3:0] AM_BIDXO = 4'd7;
  localparam logic [3:0] AM_PCREL = 4'd8;
  localparam logic [3:0] AM_AINC  = 4'd9;
  localparam logic [3:0] AM_ADEC  = 4'd10;

  typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} ea_state_e;

endpackage

// File: rtl/ea_gen_rstsync.sv
module ea_gen_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ea_gen_disp.sv
module ea_gen_disp #(
  parameter int AW      = 16,
  parameter int SHORT_W = 8
) (
  input  logic [AW-1:0] disp_i,
  input  logic          short_i,
  output logic [AW-1:0] x_o
);
  localparam int PAD_W = AW - SHORT_W;

  generate
    if (PAD_W > 0) begin : g_ext
      logic [AW-1:0] ext;
      assign ext = {{PAD_W{disp_i[SHORT_W-1]}}, disp_i[SHORT_W-1:0]};
      assign x_o = short_i ? ext : disp_i;
    end else begin : g_full
      logic unused_short;
      assign unused_short = short_i;
      assign x_o = disp_i;
    end
  endgenerate
endmodule

// File: rtl/ea_gen_calc.sv
module ea_gen_calc
  import ea_gen_pkg::*;
#(
  parameter int AW  = 16,
  parameter int SZW = 2
) (
  input  logic [3:0]     mode_i,
  input  logic [SZW-1:0] size_i,
  input  logic [AW-1:0]  x_i,
  input  logic [AW-1:0]  ra_i,
  input  logic [AW-1:0]  rb_i,
  input  logic [AW-1:0]  pc_i,
  output logic [AW-1:0]  ea_o,
  output logic           imm_o,
  output logic           reg_o,
  output logic           ill_o,
  output logic           mind_o,
  output logic           wb_en_o,
  output logic [AW-1:0]  wb_val_o
);
  logic [AW-1:0] step;
  logic [AW-1:0] ra_dec;

  assign step   = AW'(1) << size_i;
  assign ra_dec = ra_i - step;

  always_comb begin
    ea_o     = '0;
    imm_o    = 1'b0;
    reg_o    = 1'b0;
    ill_o    = 1'b0;
    mind_o   = 1'b0;
    wb_en_o  = 1'b0;
    wb_val_o = ra_i;
    case (mode_i)
      AM_IMM:   begin ea_o = x_i; imm_o = 1'b1; end
      AM_REG:   begin ea_o = ra_i; reg_o = 1'b1; end
      AM_ABS:   ea_o = x_i;
      AM_RIND:  ea_o = ra_i;
      AM_MIND:  begin ea_o = x_i; mind_o = 1'b1; end
      AM_IDX:   ea_o = x_i + ra_i;
      AM_BIDX:  ea_o = ra_i + rb_i;
      AM_BIDXO: ea_o = x_i + ra_i + rb_i;
      AM_PCREL: ea_o = pc_i + x_i;
      AM_AINC:  begin ea_o = ra_i; wb_en_o = 1'b1; wb_val_o = ra_i + step; end
      AM_ADEC:  begin ea_o = ra_dec; wb_en_o = 1'b1; wb_val_o = ra_dec; end
      default:  ill_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/ea_gen_ctrl.sv
module ea_gen_ctrl
  import ea_gen_pkg::*;
#(
  parameter int AW = 16,
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] c_ea_i,
  input  logic          c_imm_i,
  input  logic          c_reg_i,
  input  logic          c_ill_i,
  input  logic          c_mind_i,
  input  logic          c_wb_en_i,
  input  logic [AW-1:0] c_wb_val_i,
  input  logic [RW-1:0] ra_idx_i,
  input  logic          fetch_vld_i,
  input  logic [AW-1:0] fetch_data_i,
  output logic          fetch_req_o,
  output logic [AW-1:0] fetch_addr_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] ea_o,
  output logic          imm_o,
  output logic          reg_o,
  output logic          ill_o,
  output logic          wb_en_o,
  output logic [RW-1:0] wb_idx_o,
  output logic [AW-1:0] wb_val_o
);
  ea_state_e     state_q, state_d;
  logic          done_q, done_d;
  logic          wb_en_q, wb_en_d;
  logic          imm_q, imm_d, reg_q, reg_d, ill_q, ill_d;
  logic [AW-1:0] ea_q, ea_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic [RW-1:0] wb_idx_q, wb_idx_d;
  logic [AW-1:0] wb_val_q, wb_val_d;
  logic          accept, reply, res_en, ptr_en;

  assign accept = (state_q == ST_IDLE) && start_i;
  assign reply  = (state_q == ST_WAIT) && fetch_vld_i;
  assign res_en = (accept && !c_mind_i) || reply;
  assign ptr_en = accept && c_mind_i;

  always_comb begin
    state_d  = state_q;
    done_d   = 1'b0;
    wb_en_d  = 1'b0;
    imm_d    = imm_q;
    reg_d    = reg_q;
    ill_d    = ill_q;
    ea_d     = ea_q;
    ptr_d    = ptr_q;
    wb_idx_d = wb_idx_q;
    wb_val_d = wb_val_q;
    if (accept) begin
      if (c_mind_i) begin
        state_d = ST_WAIT;
        ptr_d   = c_ea_i;
      end else begin
        done_d   = 1'b1;
        ea_d     = c_ea_i;
        imm_d    = c_imm_i;
        reg_d    = c_reg_i;
        ill_d    = c_ill_i;
        wb_en_d  = c_wb_en_i;
        wb_idx_d = ra_idx_i;
        wb_val_d = c_wb_val_i;
      end
    end else if (reply) begin
      state_d = ST_IDLE;
      done_d  = 1'b1;
      ea_d    = fetch_data_i;
      imm_d   = 1'b0;
      reg_d   = 1'b0;
      ill_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      wb_en_q <= 1'b0;
      imm_q   <= 1'b0;
      reg_q   <= 1'b0;
      ill_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      wb_en_q <= wb_en_d;
      if (res_en) begin
        imm_q <= imm_d;
        reg_q <= reg_d;
        ill_q <= ill_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (res_en) begin
      ea_q     <= ea_d;
      wb_idx_q <= wb_idx_d;
      wb_val_q <= wb_val_d;
    end
    if (ptr_en) ptr_q <= ptr_d;
  end

  assign fetch_req_o  = (state_q == ST_WAIT);
  assign busy_o       = (state_q == ST_WAIT);
  assign fetch_addr_o = ptr_q;
  assign done_o       = done_q;
  assign ea_o         = ea_q;
  assign imm_o        = imm_q;
  assign reg_o        = reg_q;
  assign ill_o        = ill_q;
  assign wb_en_o      = wb_en_q;
  assign wb_idx_o     = wb_idx_q;
  assign wb_val_o     = wb_val_q;
endmodule

// File: rtl/ea_gen.sv
module ea_gen #(
  parameter int AW      = 16,
  parameter int SHORT_W = 8,
  parameter int RW      = 3,
  parameter int SZW     = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [3:0]     mode_i,
  input  logic [SZW-1:0] size_i,
  input  logic [RW-1:0]  ra_idx_i,
  input  logic [AW-1:0]  ra_val_i,
  input  logic [AW-1:0]  rb_val_i,
  input  logic [AW-1:0]  pc_i,
  input  logic [AW-1:0]  disp_i,
  input  logic           disp_short_i,
  input  logic           fetch_vld_i,
  input  logic [AW-1:0]  fetch_data_i,
  output logic           fetch_req_o,
  output logic [AW-1:0]  fetch_addr_o,
  output logic           busy_o,
  output logic           done_o,
  output logic [AW-1:0]  ea_o,
  output logic           imm_o,
  output logic           reg_op_o,
  output logic           illegal_o,
  output logic           wb_en_o,
  output logic [RW-1:0]  wb_idx_o,
  output logic [AW-1:0]  wb_val_o
);
  logic          rst_sync_n;
  logic [AW-1:0] x_val;
  logic [AW-1:0] c_ea, c_wb_val;
  logic          c_imm, c_reg, c_ill, c_mind, c_wb_en;

  ea_gen_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  ea_gen_disp #(.AW(AW), .SHORT_W(SHORT_W)) u_disp (
    .disp_i(disp_i), .short_i(disp_short_i), .x_o(x_val)
  );

  ea_gen_calc #(.AW(AW), .SZW(SZW)) u_calc (
    .mode_i(mode_i), .size_i(size_i), .x_i(x_val), .ra_i(ra_val_i),
    .rb_i(rb_val_i), .pc_i(pc_i), .ea_o(c_ea), .imm_o(c_imm),
    .reg_o(c_reg), .ill_o(c_ill), .mind_o(c_mind), .wb_en_o(c_wb_en),
    .wb_val_o(c_wb_val)
  );

  ea_gen_ctrl #(.AW(AW), .RW(RW)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .start_i(start_i),
    .c_ea_i(c_ea), .c_imm_i(c_imm), .c_reg_i(c_reg), .c_ill_i(c_ill),
    .c_mind_i(c_mind), .c_wb_en_i(c_wb_en), .c_wb_val_i(c_wb_val),
    .ra_idx_i(ra_idx_i), .fetch_vld_i(fetch_vld_i),
    .fetch_data_i(fetch_data_i), .fetch_req_o(fetch_req_o),
    .fetch_addr_o(fetch_addr_o), .busy_o(busy_o), .done_o(done_o),
    .ea_o(ea_o), .imm_o(imm_o), .reg_o(reg_op_o), .ill_o(illegal_o),
    .wb_en_o(wb_en_o), .wb_idx_o(wb_idx_o), .wb_val_o(wb_val_o)
  );
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic          start_i,
  input logic [3:0]    mode_i,
  input logic          fetch_vld_i,
  input logic [AW-1:0] fetch_data_i,
  input logic          fetch_req_o,
  input logic [AW-1:0] fetch_addr_o,
  input logic          busy_o,
  input logic          done_o,
  input logic [AW-1:0] ea_o,
  input logic          imm_o,
  input logic          reg_op_o,
  input logic          illegal_o,
  input logic          wb_en_o
);
  a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (start_i && !busy_o && mode_i != 4'd4) |=> done_o);

  a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fetch_req_o && !fetch_vld_i) |=> (fetch_req_o && $stable(fetch_addr_o)));

  a_r7_reply_done: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fetch_req_o && fetch_vld_i) |=> (done_o && !fetch_req_o && ea_o == $past(fetch_data_i)));

  a_r9_wb_with_done: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wb_en_o |-> (done_o && !illegal_o && !imm_o && !reg_op_o));

  a_r10_illegal_clean: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done_o && illegal_o) |-> (!wb_en_o && ea_o == '0));

  a_r11_busy_ignores: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy_o && start_i && !fetch_vld_i) |=> (!done_o && !wb_en_o));

  a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |-> $onehot0({imm_o, reg_op_o, illegal_o}));
endmodule

bind ea_gen ea_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .start_i(start_i), .mode_i(mode_i),
  .fetch_vld_i(fetch_vld_i), .fetch_data_i(fetch_data_i),
  .fetch_req_o(fetch_req_o), .fetch_addr_o(fetch_addr_o), .busy_o(busy_o),
  .done_o(done_o), .ea_o(ea_o), .imm_o(imm_o), .reg_op_o(reg_op_o),
  .illegal_o(illegal_o), .wb_en_o(wb_en_o)
);

// File: tb/ea_gen_bench.sv
module ea_gen_bench;
  localparam int AW = 16;
  localparam int RW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [3:0]    mode_i = '0;
  logic [1:0]    size_i = '0;
  logic [RW-1:0] ra_idx_i = '0;
  logic [AW-1:0] ra_val_i = '0, rb_val_i = '0, pc_i = '0, disp_i = '0;
  logic          disp_short_i = 1'b0;
  logic          fetch_vld_i = 1'b0;
  logic [AW-1:0] fetch_data_i = '0;
  logic          fetch_req_o, busy_o, done_o, imm_o, reg_op_o, illegal_o, wb_en_o;
  logic [AW-1:0] fetch_addr_o, ea_o, wb_val_o;
  logic [RW-1:0] wb_idx_o;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ea_gen u_ea_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .size_i(size_i), .ra_idx_i(ra_idx_i), .ra_val_i(ra_val_i),
    .rb_val_i(rb_val_i), .pc_i(pc_i), .disp_i(disp_i),
    .disp_short_i(disp_short_i), .fetch_vld_i(fetch_vld_i),
    .fetch_data_i(fetch_data_i), .fetch_req_o(fetch_req_o),
    .fetch_addr_o(fetch_addr_o), .busy_o(busy_o), .done_o(done_o),
    .ea_o(ea_o), .imm_o(imm_o), .reg_op_o(reg_op_o), .illegal_o(illegal_o),
    .wb_en_o(wb_en_o), .wb_idx_o(wb_idx_o), .wb_val_o(wb_val_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int xval(input int d, input bit sh);
    int lo;
    if (!sh) return d & 32'hFFFF;
    lo = d & 32'hFF;
    if (lo >= 128) lo = lo - 256;
    return lo & 32'hFFFF;
  endfunction

  task automatic run_op(input int m, input int sz, input int ra, input int rb,
                        input int pc, input int d, input bit sh, input int idx,
                        input int lat, input int fdata, input bit stray);
    int x, exp_ea, exp_wb, st;
    bit e_imm, e_reg, e_ill, e_wb;
    x = xval(d, sh);
    st = 1 << sz;
    e_imm = 0; e_reg = 0; e_ill = 0; e_wb = 0; exp_wb = 0; exp_ea = 0;
    case (m)
      0: begin exp_ea = x; e_imm = 1; end
      1: begin exp_ea = ra; e_reg = 1; end
      2: exp_ea = x;
      3: exp_ea = ra;
      4: exp_ea = fdata;
      5: exp_ea = x + ra;
      6: exp_ea = ra + rb;
      7: exp_ea = x + ra + rb;
      8: exp_ea = pc + x;
      9: begin exp_ea = ra; e_wb = 1; exp_wb = ra + st; end
      10: begin exp_ea = ra - st; e_wb = 1; exp_wb = ra - st; end
      default: e_ill = 1;
    endcase
    exp_ea = exp_ea & 32'hFFFF;
    exp_wb = exp_wb & 32'hFFFF;
    @(negedge clk);
    mode_i = 4'(m); size_i = 2'(sz); ra_val_i = 16'(ra); rb_val_i = 16'(rb);
    pc_i = 16'(pc); disp_i = 16'(d); disp_short_i = sh; ra_idx_i = 3'(idx);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (m == 4) begin
      check(fetch_req_o === 1'b1, "R7 fetch_req", int'(fetch_req_o), 1);
      check(fetch_addr_o === 16'(x), "R7/R3 fetch_addr", int'(fetch_addr_o), x);
      for (int w = 0; w < lat; w++) begin
        if (stray && w == 0) begin
          mode_i = 4'd9; start_i = 1'b1;
        end
        @(negedge clk);
        start_i = 1'b0;
        check(done_o === 1'b0 && wb_en_o === 1'b0, "R11 stray/wait no done",
              int'({done_o, wb_en_o}), 0);
        check(fetch_req_o === 1'b1 && fetch_addr_o === 16'(x), "R7 req held",
              int'(fetch_addr_o), x);
      end
      fetch_vld_i = 1'b1; fetch_data_i = 16'(fdata);
      @(negedge clk);
      fetch_vld_i = 1'b0;
      check(done_o === 1'b1, "R7 done", int'(done_o), 1);
      check(ea_o === 16'(exp_ea), "R7 ea", int'(ea_o), exp_ea);
      check(fetch_req_o === 1'b0, "R7 req dropped", int'(fetch_req_o), 0);
      check({imm_o, reg_op_o, illegal_o, wb_en_o} === 4'b0, "R7 flags",
            int'({imm_o, reg_op_o, illegal_o, wb_en_o}), 0);
    end else begin
      check(done_o === 1'b1, "R2 done", int'(done_o), 1);
      check(ea_o === 16'(exp_ea),
            (m >= 11) ? "R10 ea" : (m == 0) ? "R4 ea" : (m <= 3) ? "R5 ea" :
            (m <= 8) ? "R6 ea" : "R8 ea", int'(ea_o), exp_ea);
      check(imm_o === e_imm, "R4 imm flag", int'(imm_o), int'(e_imm));
      check(reg_op_o === e_reg, "R5 reg flag", int'(reg_op_o), int'(e_reg));
      check(illegal_o === e_ill, "R10 illegal flag", int'(illegal_o), int'(e_ill));
      check(wb_en_o === e_wb, "R9 wb_en", int'(wb_en_o), int'(e_wb));
      if (e_wb) begin
        check(wb_val_o === 16'(exp_wb), "R8 wb_val", int'(wb_val_o), exp_wb);
        check(wb_idx_o === 3'(idx), "R9 wb_idx", int'(wb_idx_o), idx);
      end
      @(negedge clk);
      check(done_o === 1'b0 && wb_en_o === 1'b0, "R2 single pulse",
            int'({done_o, wb_en_o}), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int ras[4];
    int ds[4];
    int rbs[2];
    ras = '{0, 32'hFFFF, 32'h8000, 32'h1234};
    ds  = '{32'h007F, 32'h0080, 32'hFF80, 32'h1234};
    rbs = '{32'h0001, 32'hFFFE};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check({done_o, fetch_req_o, wb_en_o, busy_o} === 4'b0, "R1 reset ctrl",
          int'({done_o, fetch_req_o, wb_en_o, busy_o}), 0);
    check({imm_o, reg_op_o, illegal_o} === 3'b0, "R1 reset flags",
          int'({imm_o, reg_op_o, illegal_o}), 0);
    for (int m = 0; m < 16; m++)
      for (int a = 0; a < 4; a++)
        for (int k = 0; k < 4; k++)
          for (int s = 0; s < 2; s++)
            for (int z = 0; z < 4; z++)
              run_op(m, z, ras[a], rbs[(a + k) & 1], 32'hFFF0 - 32'(k * 16'h1000),
                     ds[k], s[0], (a * 4 + k + z) & 7, (a + z) % 3,
                     32'h5A00 + a * 16 + k * 4 + z, 1'b0);
    // R11 stray start during a pending fetch
    run_op(4, 2, 32'h0100, 1, 0, 32'h0044, 1'b0, 5, 2, 32'hBEEF, 1'b1);
    run_op(4, 0, 32'h0200, 1, 0, 32'h00F0, 1'b1, 6, 1, 32'hCAFE, 1'b1);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule